// File: doc/BRIEF.md
# Stack Pointer, Status Word and Register Bank Addressing Unit

This unit sits beside an 8-bit microcontroller core's internal data RAM. It holds the stack pointer and the program status word. For every stack operation it supplies the RAM address, and for stores it also supplies the data byte. A store moves the pointer up by one and then writes at the new value. A load reads at the current pointer and then moves it down by one. A call stores a 16-bit return address over two cycles, and a return loads it back in the opposite order. The RAM array itself sits outside the block.

The unit also turns a 3-bit working-register number into a RAM address, using the two bank-select bits held in the status word. It refreshes the parity flag from the accumulator value it is given. The carry, half-carry and overflow flags come from the ALU on a flag-load strobe. Software reads and writes the pointer and the status word one byte at a time through a small register port. Every interface is a plain strobe or level. The RAM is assumed to accept an access in any cycle, so the edge of the block has no back-pressure.

Top module: `stack_bank_unit`

## Requirements
- R1: After reset the pointer reads 07H and the status word reads 00H.
- R2: A push request drives ram_we high with ram_waddr equal to the pointer plus one and ram_wdata equal to push_data, in that same cycle. The pointer holds the new address after the clock edge, so the first push after reset writes to 08H.
- R3: A pop request drives ram_re high with ram_raddr equal to the current pointer in that cycle. The pointer is one less after the edge.
- R4: A call writes call_pc[7:0] at pointer+1 in the request cycle and call_pc[15:8] at the next address in the following cycle. busy is high only in that second cycle, and every stack request made while busy is high is ignored. The pointer ends two higher.
- R5: A return reads at the pointer (the high byte) in the request cycle and at the pointer minus one (the low byte) in the next cycle, with busy high in that second cycle. The pointer ends two lower.
- R6: When several stack requests arrive in one cycle, only one is taken, in the order call, return, push, pop.
- R7: rn_addr equals {3'b000, PSW[4], PSW[3], rn_sel}, which gives banks at 00H, 08H, 10H and 18H for bank bits 00, 01, 10 and 11.
- R8: The parity bit PSW[0] takes the XOR of all accumulator bits at each clock edge. The accumulator together with the parity bit therefore always holds an even number of ones.
- R9: The status word layout, from bit 7 down to bit 0, is carry, half-carry, user flag F0, bank bit 1, bank bit 0, overflow, reserved, parity. A status word write (sfr_sel=1) loads bits 7 to 2. Bit 1 always reads 0, and a written value of bit 0 has no effect.
- R10: flag_we loads cy_in, ac_in and ov_in into bits 7, 6 and 2. In the same cycle it takes precedence over a status word write to those bits.
- R11: A pointer write (sfr_sel=0) loads the pointer, and sfr_rdata returns the pointer or the status word according to sfr_sel. A pointer write wins over a stack update in the same cycle. The pointer wraps from FFH to 00H on a push and from 00H to FFH on a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_req | input | 1 | Store one byte on the stack |
| push_data | input | 8 | Byte to store |
| pop_req | input | 1 | Load one byte from the stack |
| call_req | input | 1 | Store a 16-bit return address |
| call_pc | input | 16 | Return address to store |
| ret_req | input | 1 | Load a 16-bit return address |
| busy | output | 1 | Second cycle of a call or return |
| ram_we | output | 1 | RAM write strobe |
| ram_waddr | output | 8 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| ram_re | output | 1 | RAM read strobe |
| ram_raddr | output | 8 | RAM read address |
| rn_sel | input | 3 | Working register number |
| rn_addr | output | 8 | RAM address of that register |
| acc | input | 8 | Accumulator value |
| flag_we | input | 1 | Load ALU flags |
| cy_in | input | 1 | Carry from ALU |
| ac_in | input | 1 | Half-carry from ALU |
| ov_in | input | 1 | Overflow from ALU |
| sfr_we | input | 1 | Register write strobe |
| sfr_sel | input | 1 | 0 selects pointer, 1 selects status word |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Selected register value |

## Verification
The in-RTL assertions check several things on every cycle. They check that the pointer lands on the address just written, or one below the address just read. They check that a write and a read never happen together, that an accepted call leads into its high-byte cycle and an accepted return into its low-byte cycle, and that the parity bit matches the previous accumulator value. They also check that the bank bits in rn_addr follow the status word, and that register and flag loads land in the right bits. Only the bench scenarios can show the exact byte order of a call and return pair, requests being ignored while busy, arbitration between requests made together, the values at reset, and wrap-around at both ends of the pointer range.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CALL_HI = 2'd1,
    ST_RET_LO  = 2'd2
  } stk_state_e;

  localparam logic SEL_SP  = 1'b0;
  localparam logic SEL_PSW = 1'b1;

  localparam int BIT_CY = 7;
  localparam int BIT_AC = 6;
  localparam int BIT_F0 = 5;
  localparam int BIT_B1 = 4;
  localparam int BIT_B0 = 3;
  localparam int BIT_OV = 2;
  localparam int BIT_RV = 1;
  localparam int BIT_P  = 0;
endpackage

// File: rtl/sbu_stack_ptr.sv
module sbu_stack_ptr
  import sbu_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int PCW = 16,
  parameter logic [AW-1:0] SP_RST = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  input  logic          call_req,
  input  logic [PCW-1:0] call_pc,
  input  logic          ret_req,
  input  logic          sp_wr,
  input  logic [AW-1:0] sp_wdata,
  output logic [AW-1:0] sp_q,
  output logic          busy,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_re,
  output logic [AW-1:0] ram_raddr
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  stk_state_e     state_q, state_d;
  logic [AW-1:0]  sp_d;
  logic [DW-1:0]  hi_q, hi_d;
  logic [AW-1:0]  sp_up, sp_dn;

  assign sp_up = sp_q + ONE;
  assign sp_dn = sp_q - ONE;
  assign busy  = (state_q != ST_IDLE);

  always_comb begin
    state_d   = state_q;
    sp_d      = sp_q;
    hi_d      = hi_q;
    ram_we    = 1'b0;
    ram_waddr = sp_up;
    ram_wdata = '0;
    ram_re    = 1'b0;
    ram_raddr = sp_q;
    unique case (state_q)
      ST_IDLE: begin
        if (call_req) begin
          ram_we    = 1'b1;
          ram_wdata = call_pc[DW-1:0];
          hi_d      = call_pc[PCW-1:DW];
          sp_d      = sp_up;
          state_d   = ST_CALL_HI;
        end else if (ret_req) begin
          ram_re  = 1'b1;
          sp_d    = sp_dn;
          state_d = ST_RET_LO;
        end else if (push_req) begin
          ram_we    = 1'b1;
          ram_wdata = push_data;
          sp_d      = sp_up;
        end else if (pop_req) begin
          ram_re = 1'b1;
          sp_d   = sp_dn;
        end
      end
      ST_CALL_HI: begin
        ram_we    = 1'b1;
        ram_wdata = hi_q;
        sp_d      = sp_up;
        state_d   = ST_IDLE;
      end
      ST_RET_LO: begin
        ram_re  = 1'b1;
        sp_d    = sp_dn;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (sp_wr) sp_d = sp_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sp_q    <= SP_RST;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      sp_q    <= sp_d;
      hi_q    <= hi_d;
    end
  end

  // R2: pointer lands on the address just written
  p_push_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !sp_wr) |=> (sp_q == $past(ram_waddr)));

  // R3: pointer ends one below the address just read
  p_pop_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_re && !sp_wr) |=> (sp_q == $past(ram_raddr) - ONE));

  // R4: accepted call continues with its high byte
  p_call_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && call_req) |=> (busy && ram_we && ram_wdata == $past(call_pc[PCW-1:DW])));

  // R5: accepted return continues with its low-byte read
  p_ret_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ret_req && !call_req) |=> (busy && ram_re && !ram_we));

  // R6: never a read and a write together
  p_one_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && ram_re));
endmodule

// File: rtl/sbu_psw.sv
module sbu_psw
  import sbu_pkg::*;
#(
  parameter int DW = 8,
  parameter int BS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   acc,
  input  logic            flag_we,
  input  logic            cy_in,
  input  logic            ac_in,
  input  logic            ov_in,
  input  logic            psw_wr,
  input  logic [DW-1:0]   psw_wdata,
  output logic [DW-1:0]   psw_q,
  output logic [BS_W-1:0] bank
);
  logic cy_q, ac_q, f0_q, ov_q, par_q;
  logic [BS_W-1:0] bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cy_q   <= 1'b0;
      ac_q   <= 1'b0;
      f0_q   <= 1'b0;
      ov_q   <= 1'b0;
      bank_q <= '0;
      par_q  <= 1'b0;
    end else begin
      par_q <= ^acc;
      if (psw_wr) begin
        f0_q   <= psw_wdata[BIT_F0];
        bank_q <= psw_wdata[BIT_B1:BIT_B0];
      end
      if (flag_we) begin
        cy_q <= cy_in;
        ac_q <= ac_in;
        ov_q <= ov_in;
      end else if (psw_wr) begin
        cy_q <= psw_wdata[BIT_CY];
        ac_q <= psw_wdata[BIT_AC];
        ov_q <= psw_wdata[BIT_OV];
      end
    end
  end

  assign psw_q = {cy_q, ac_q, f0_q, bank_q, ov_q, 1'b0, par_q};
  assign bank  = bank_q;

  // R8: parity flag makes accumulator plus flag even
  p_even_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((^{$past(acc), psw_q[BIT_P]}) == 1'b0));

  // R10: ALU flags land in carry, half-carry, overflow
  p_flag_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> (psw_q[BIT_CY] == $past(cy_in) && psw_q[BIT_AC] == $past(ac_in)
                 && psw_q[BIT_OV] == $past(ov_in)));

  // R9: register write loads the upper six bits
  p_psw_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (psw_wr && !flag_we) |=> (psw_q[7:2] == $past(psw_wdata[7:2]) && !psw_q[BIT_RV]));
endmodule

// File: rtl/sbu_bank_addr.sv
module sbu_bank_addr #(
  parameter int AW = 8,
  parameter int RN_W = 3,
  parameter int BS_W = 2
) (
  input  logic [RN_W-1:0] rn_sel,
  input  logic [BS_W-1:0] bank,
  output logic [AW-1:0]   rn_addr
);
  localparam int PAD_W = AW - BS_W - RN_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign rn_addr = {{PAD_W{1'b0}}, bank, rn_sel};
    end else begin : g_nopad
      assign rn_addr = {bank, rn_sel};
    end
  endgenerate
endmodule

// File: rtl/stack_bank_unit.sv
module stack_bank_unit
  import sbu_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int PCW = 16,
  parameter int RN_W = 3,
  parameter int BS_W = 2,
  parameter logic [AW-1:0] SP_RST = 8'h07
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push_req,
  input  logic [DW-1:0]  push_data,
  input  logic           pop_req,
  input  logic           call_req,
  input  logic [PCW-1:0] call_pc,
  input  logic           ret_req,
  output logic           busy,
  output logic           ram_we,
  output logic [AW-1:0]  ram_waddr,
  output logic [DW-1:0]  ram_wdata,
  output logic           ram_re,
  output logic [AW-1:0]  ram_raddr,
  input  logic [RN_W-1:0] rn_sel,
  output logic [AW-1:0]  rn_addr,
  input  logic [DW-1:0]  acc,
  input  logic           flag_we,
  input  logic           cy_in,
  input  logic           ac_in,
  input  logic           ov_in,
  input  logic           sfr_we,
  input  logic           sfr_sel,
  input  logic [DW-1:0]  sfr_wdata,
  output logic [DW-1:0]  sfr_rdata
);
  logic [AW-1:0]   sp_q;
  logic [DW-1:0]   psw_q;
  logic [BS_W-1:0] bank;
  logic            sp_wr, psw_wr;

  assign sp_wr  = sfr_we && (sfr_sel == SEL_SP);
  assign psw_wr = sfr_we && (sfr_sel == SEL_PSW);

  sbu_stack_ptr #(.AW(AW), .DW(DW), .PCW(PCW), .SP_RST(SP_RST)) u_sp (
    .clk(clk), .rst_n(rst_n),
    .push_req(push_req), .push_data(push_data), .pop_req(pop_req),
    .call_req(call_req), .call_pc(call_pc), .ret_req(ret_req),
    .sp_wr(sp_wr), .sp_wdata(sfr_wdata[AW-1:0]), .sp_q(sp_q), .busy(busy),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .ram_re(ram_re), .ram_raddr(ram_raddr)
  );

  sbu_psw #(.DW(DW), .BS_W(BS_W)) u_psw (
    .clk(clk), .rst_n(rst_n), .acc(acc),
    .flag_we(flag_we), .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in),
    .psw_wr(psw_wr), .psw_wdata(sfr_wdata), .psw_q(psw_q), .bank(bank)
  );

  sbu_bank_addr #(.AW(AW), .RN_W(RN_W), .BS_W(BS_W)) u_bank (
    .rn_sel(rn_sel), .bank(bank), .rn_addr(rn_addr)
  );

  always_comb begin
    sfr_rdata = psw_q;
    if (sfr_sel == SEL_SP) sfr_rdata = sp_q;
  end

  // R7: bank field of the register address follows the status word
  p_bank_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rn_addr[RN_W+BS_W-1:RN_W] == psw_q[BIT_B1:BIT_B0]) && (rn_addr[RN_W-1:0] == rn_sel));

  // R11: pointer write wins over any stack update
  p_sp_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr |=> (sp_q == $past(sfr_wdata)));
endmodule

// File: tb/stack_bank_unit_test.sv
module stack_bank_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_req = 0, pop_req = 0, call_req = 0, ret_req = 0;
  logic [7:0]  push_data = 0;
  logic [15:0] call_pc = 0;
  logic        busy, ram_we, ram_re;
  logic [7:0]  ram_waddr, ram_wdata, ram_raddr;
  logic [2:0]  rn_sel = 0;
  logic [7:0]  rn_addr;
  logic [7:0]  acc = 0;
  logic        flag_we = 0, cy_in = 0, ac_in = 0, ov_in = 0;
  logic        sfr_we = 0, sfr_sel = 0;
  logic [7:0]  sfr_wdata = 0, sfr_rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  stack_bank_unit uut (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_data(push_data),
    .pop_req(pop_req), .call_req(call_req), .call_pc(call_pc), .ret_req(ret_req),
    .busy(busy), .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .ram_re(ram_re), .ram_raddr(ram_raddr), .rn_sel(rn_sel), .rn_addr(rn_addr),
    .acc(acc), .flag_we(flag_we), .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in),
    .sfr_we(sfr_we), .sfr_sel(sfr_sel), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // inputs change on falling edges; outputs sampled 1 ns later
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_in();
    push_req = 0; pop_req = 0; call_req = 0; ret_req = 0;
    sfr_we = 0; flag_we = 0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    sfr_sel = sel;
    #1 v = sfr_rdata;
  endtask

  task automatic wr(input logic sel, input logic [7:0] v);
    sfr_we = 1; sfr_sel = sel; sfr_wdata = v;
    tick();
    sfr_we = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b0, v); chk(v == 8'h07, "R1 sp reset", v, 8'h07);
    rd(1'b1, v); chk(v == 8'h00, "R1 psw reset", v, 8'h00);
    chk(busy == 0, "R1 busy reset", busy, 0);
  endtask

  task automatic t_push_pop();
    logic [7:0] v;
    push_req = 1; push_data = 8'hAA; #1;
    chk(ram_we && ram_waddr == 8'h08, "R2 first push addr", ram_waddr, 8'h08);
    chk(ram_wdata == 8'hAA, "R2 push data", ram_wdata, 8'hAA);
    tick();
    push_data = 8'hBB; #1;
    chk(ram_waddr == 8'h09 && ram_wdata == 8'hBB, "R2 second push", ram_waddr, 8'h09);
    tick(); push_req = 0;
    rd(1'b0, v); chk(v == 8'h09, "R2 sp after pushes", v, 8'h09);
    pop_req = 1; #1;
    chk(ram_re && !ram_we && ram_raddr == 8'h09, "R3 pop addr", ram_raddr, 8'h09);
    tick(); #1;
    chk(ram_raddr == 8'h08, "R3 second pop addr", ram_raddr, 8'h08);
    tick(); pop_req = 0;
    rd(1'b0, v); chk(v == 8'h07, "R3 sp after pops", v, 8'h07);
  endtask

  task automatic t_call_ret();
    logic [7:0] v;
    call_req = 1; call_pc = 16'h1234; #1;
    chk(ram_we && ram_waddr == 8'h08 && ram_wdata == 8'h34 && !busy,
        "R4 call low byte", {ram_waddr, ram_wdata}, 16'h0834);
    tick(); call_req = 0;
    push_req = 1; push_data = 8'hEE; pop_req = 1; ret_req = 1; #1;
    chk(busy && ram_we && ram_waddr == 8'h09 && ram_wdata == 8'h12,
        "R4 call high byte", {ram_waddr, ram_wdata}, 16'h0912);
    tick(); clear_in();
    rd(1'b0, v); chk(v == 8'h09, "R4 sp after call, busy requests ignored", v, 8'h09);
    chk(!busy && !ram_we && !ram_re, "R4 idle after call", busy, 0);
    ret_req = 1; #1;
    chk(ram_re && ram_raddr == 8'h09 && !busy, "R5 ret high read", ram_raddr, 8'h09);
    tick(); ret_req = 0; #1;
    chk(busy && ram_re && ram_raddr == 8'h08, "R5 ret low read", ram_raddr, 8'h08);
    tick();
    rd(1'b0, v); chk(v == 8'h07, "R5 sp after ret", v, 8'h07);
  endtask

  task automatic t_priority();
    logic [7:0] v;
    call_req = 1; call_pc = 16'hBEEF; push_req = 1; push_data = 8'h55; pop_req = 1; #1;
    chk(ram_wdata == 8'hEF && ram_waddr == 8'h08, "R6 call beats push", ram_wdata, 8'hEF);
    tick(); clear_in(); tick();
    ret_req = 1; pop_req = 1; push_req = 1; #1;
    chk(ram_re && !ram_we && ram_raddr == 8'h09, "R6 ret beats push", ram_raddr, 8'h09);
    tick(); clear_in(); tick();
    push_req = 1; pop_req = 1; push_data = 8'h66; #1;
    chk(ram_we && !ram_re && ram_waddr == 8'h08, "R6 push beats pop", ram_waddr, 8'h08);
    tick(); clear_in();
    rd(1'b0, v); chk(v == 8'h08, "R6 sp after push", v, 8'h08);
    wr(1'b0, 8'h07);
  endtask

  task automatic t_bank();
    wr(1'b1, 8'h10); rn_sel = 3'd5; #1;
    chk(rn_addr == 8'h15, "R7 bank 2 r5", rn_addr, 8'h15);
    wr(1'b1, 8'h18); rn_sel = 3'd7; #1;
    chk(rn_addr == 8'h1F, "R7 bank 3 r7", rn_addr, 8'h1F);
    wr(1'b1, 8'h08); rn_sel = 3'd3; #1;
    chk(rn_addr == 8'h0B, "R7 bank 1 r3", rn_addr, 8'h0B);
    wr(1'b1, 8'h00); rn_sel = 3'd0; #1;
    chk(rn_addr == 8'h00, "R7 bank 0 r0", rn_addr, 8'h00);
  endtask

  task automatic t_parity();
    logic [7:0] v;
    acc = 8'h07; tick();
    rd(1'b1, v); chk(v[0] == 1'b1, "R8 odd acc parity", v[0], 1);
    acc = 8'h03; tick();
    rd(1'b1, v); chk(v[0] == 1'b0, "R8 even acc parity", v[0], 0);
    wr(1'b1, 8'hFF);
    rd(1'b1, v); chk(v == 8'hFC, "R9 psw write, bit1 zero, parity kept", v, 8'hFC);
    acc = 8'h01; tick();
    rd(1'b1, v); chk(v == 8'hFD, "R9 parity follows acc", v, 8'hFD);
    wr(1'b1, 8'h01);
    rd(1'b1, v); chk(v == 8'h01, "R9 bit0 write ignored", v, 8'h01);
  endtask

  task automatic t_flags();
    logic [7:0] v;
    acc = 8'h00;
    flag_we = 1; cy_in = 1; ac_in = 0; ov_in = 1;
    sfr_we = 1; sfr_sel = 1'b1; sfr_wdata = 8'h48;
    tick(); clear_in();
    rd(1'b1, v); chk(v == 8'h8C, "R10 flags win over psw write", v, 8'h8C);
    flag_we = 1; cy_in = 0; ac_in = 1; ov_in = 0; tick(); clear_in();
    rd(1'b1, v); chk(v == 8'h48, "R10 flag load keeps F0 and bank", v, 8'h48);
    wr(1'b1, 8'h00);
  endtask

  task automatic t_sp_wrap();
    logic [7:0] v;
    wr(1'b0, 8'hFF);
    rd(1'b0, v); chk(v == 8'hFF, "R11 sp write readback", v, 8'hFF);
    push_req = 1; push_data = 8'h11; #1;
    chk(ram_waddr == 8'h00, "R11 push wraps", ram_waddr, 8'h00);
    tick(); clear_in();
    rd(1'b0, v); chk(v == 8'h00, "R11 sp at 00", v, 8'h00);
    pop_req = 1; #1;
    chk(ram_raddr == 8'h00, "R11 pop at 00", ram_raddr, 8'h00);
    tick(); clear_in();
    rd(1'b0, v); chk(v == 8'hFF, "R11 pop wraps", v, 8'hFF);
    push_req = 1; sfr_we = 1; sfr_sel = 1'b0; sfr_wdata = 8'h40;
    tick(); clear_in();
    rd(1'b0, v); chk(v == 8'h40, "R11 sp write beats push", v, 8'h40);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_push_pop();
        t_call_ret();
        t_priority();
        t_bank();
        t_parity();
        t_flags();
        t_sp_wrap();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule